// File: doc/BRIEF.md
# Embedded Controller Host Mailbox Port

This block sits on the device side of a byte-wide host port that gives the host access to an embedded controller's internal register space. The host sees two locations. The data location (`host_sel` = 0, host offset 0) carries address and data bytes in and result bytes out. The control location (`host_sel` = 1, host offset 4) returns a status byte when read and accepts a command byte when written. Two flags in the status byte pace every transfer. The input-full flag stays set while a byte from the host has not yet been taken and released. The output-full flag shows that a result byte is waiting for the host.

A read transaction is a command byte 0x80 followed by one address byte. The block then fetches the addressed register and raises the output-full flag. A write transaction is a command byte 0x81, then an address byte, then a data byte. The internal register file is a synchronous single-port memory sized by a parameter. Addresses beyond its depth read as zero, and writes to them are dropped. Command codes 0x82, 0x83 and 0x84 are taken from the host but have no effect. Any other command code, or a fresh 0x80 or 0x81, abandons the transaction in progress.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00 and the data location reads 0x00.
- R2: Status byte layout: bit 0 is output-full, bit 1 is input-full, bit 3 is 1 when the last accepted host byte was written to the control location and 0 when it went to the data location, and bits 2 and 7:4 read 0. A host read strobe returns its byte on `host_rdata` one clock later.
- R3: A host write accepted while input-full is clear sets input-full. Input-full then stays set for exactly 1 + IBF_HOLD clocks and clears by itself.
- R4: A host write presented while input-full is set is discarded and has no effect on the transaction in progress.
- R5: After command 0x80 and an address byte, output-full is set on the third status read strobed continuously from the clock after the address write. The data location then returns the register value, and reading the data location clears output-full.
- R6: Command 0x81 followed by an address byte and a data byte stores the data byte at that address.
- R7: Command codes 0x82, 0x83 and 0x84 leave a read or write transaction in progress undisturbed.
- R8: A read of an address at or above REG_DEPTH returns 0x00, and a write to such an address changes no register.
- R9: Command 0x80 or 0x81 received in mid-transaction restarts the sequence. Any other unlisted command code returns the sequencer to idle. A data byte received while idle is discarded, and output-full stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one clock per byte |
| host_rd | input | 1 | Host read strobe, one clock per byte |
| host_sel | input | 1 | 0 selects the data location, 1 the status/command location |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Registered byte returned to the host |

## Verification
The bench builds the block with REG_DEPTH = 16 and IBF_HOLD = 2. The small depth lets one sweep write and then read back every one of the 256 byte addresses. That sweep covers the implemented range and the out-of-range zero-read and dropped-write behaviour in a single pass. The short hold window lets exact cycle counts be measured from continuous status polling: the input-full duration and the output-full arrival delay. The ordering cases are driven as explicit byte sequences, and each one is judged by reading back registers through the host port: ignored codes, aborted transactions, stray data bytes and writes made while the port is busy.

// File: rtl/ec_port_pkg.sv
package ec_port_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_RD_ADDR = 2'd1,
    SQ_WR_ADDR = 2'd2,
    SQ_WR_DATA = 2'd3
  } seq_state_e;

  localparam logic [7:0] OP_READ      = 8'h80;
  localparam logic [7:0] OP_WRITE     = 8'h81;
  localparam logic [7:0] OP_BURST_ON  = 8'h82;
  localparam logic [7:0] OP_BURST_OFF = 8'h83;
  localparam logic [7:0] OP_QUERY     = 8'h84;

  localparam int ST_OBF_BIT = 0;
  localparam int ST_IBF_BIT = 1;
  localparam int ST_CMD_BIT = 3;

  function automatic logic op_is_inert(input logic [7:0] code);
    return (code == OP_BURST_ON) || (code == OP_BURST_OFF) || (code == OP_QUERY);
  endfunction

endpackage

// File: rtl/ec_port_regfile.sv
module ec_port_regfile #(
  parameter int AW    = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [7:0]    rdata_q;
  logic          in_range;
  logic [IW-1:0] idx;

  assign in_range = ({1'b0, addr} < (AW+1)'(DEPTH));
  assign idx      = addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (wr_en && in_range) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= in_range ? mem[idx] : 8'h00;
  end

  assign rdata = rdata_q;

  AST_RANGE_READ_ZERO: assert property (@(posedge clk)
    (rd_en && !in_range) |=> (rdata == 8'h00)); // R8

endmodule

// File: rtl/ec_port_ibf_timer.sv
module ec_port_ibf_timer #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic consume_i,
  output logic ibf_o
);
  localparam int CW = $clog2(HOLD + 2);

  logic          ibf_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ibf_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (set_i) begin
      ibf_q <= 1'b1;
    end else if (consume_i) begin
      if (HOLD == 0) begin
        ibf_q <= 1'b0;
      end else begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(HOLD);
      end
    end else if (busy_q) begin
      if (cnt_q == CW'(1)) begin
        ibf_q  <= 1'b0;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign ibf_o = ibf_q;

  AST_IBF_HOLD_WINDOW: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (ibf_q && cnt_q != '0 && cnt_q <= CW'(HOLD))); // R3

endmodule

// File: rtl/ec_port_seq.sv
module ec_port_seq
  import ec_port_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_vld,
  input  logic [7:0]    byte_i,
  input  logic          byte_is_cmd,
  output logic          consume_o,
  output logic          reg_rd_en,
  output logic          reg_wr_en,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          load_out_o
);
  seq_state_e    st_q, st_d;
  logic [AW-1:0] addr_q;
  logic          load_q;
  logic          data_vld;

  assign data_vld  = byte_vld && !byte_is_cmd;
  assign consume_o = byte_vld;
  assign reg_rd_en = data_vld && (st_q == SQ_RD_ADDR);
  assign reg_wr_en = data_vld && (st_q == SQ_WR_DATA);
  assign reg_addr  = reg_rd_en ? AW'(byte_i) : addr_q;
  assign reg_wdata = byte_i;

  always_comb begin
    st_d = st_q;
    if (byte_vld) begin
      if (byte_is_cmd) begin
        if (byte_i == OP_READ)       st_d = SQ_RD_ADDR;
        else if (byte_i == OP_WRITE) st_d = SQ_WR_ADDR;
        else if (op_is_inert(byte_i)) st_d = st_q;
        else                          st_d = SQ_IDLE;
      end else begin
        case (st_q)
          SQ_RD_ADDR: st_d = SQ_IDLE;
          SQ_WR_ADDR: st_d = SQ_WR_DATA;
          SQ_WR_DATA: st_d = SQ_IDLE;
          default:    st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      load_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      load_q <= reg_rd_en;
      if (data_vld && st_q == SQ_WR_ADDR) addr_q <= AW'(byte_i);
    end
  end

  assign load_out_o = load_q;

  AST_INERT_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_is_cmd && op_is_inert(byte_i)) |=> $stable(st_q)); // R7

  AST_NEW_CMD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && byte_is_cmd && byte_i == OP_WRITE) |=> (st_q == SQ_WR_ADDR)); // R9

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
  import ec_port_pkg::*;
#(
  parameter int REG_DEPTH = 32,
  parameter int IBF_HOLD  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic       host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam int AW = 8;

  logic          ibf;
  logic          accept;
  logic          consume;
  logic [7:0]    in_byte_q;
  logic          in_cmd_q;
  logic          in_pend_q;
  logic [7:0]    out_byte_q;
  logic          obf_q;
  logic [7:0]    rdata_q;
  logic [7:0]    status;
  logic          rf_rd_en;
  logic          rf_wr_en;
  logic [AW-1:0] rf_addr;
  logic [7:0]    rf_wdata;
  logic [7:0]    rf_rdata;
  logic          load_out;

  assign accept = host_wr && !ibf;

  always_comb begin
    status             = 8'h00;
    status[ST_OBF_BIT] = obf_q;
    status[ST_IBF_BIT] = ibf;
    status[ST_CMD_BIT] = in_cmd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_byte_q <= 8'h00;
      in_cmd_q  <= 1'b0;
      in_pend_q <= 1'b0;
    end else if (accept) begin
      in_byte_q <= host_wdata;
      in_cmd_q  <= host_sel;
      in_pend_q <= 1'b1;
    end else if (consume) begin
      in_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte_q <= 8'h00;
      obf_q      <= 1'b0;
    end else if (load_out) begin
      out_byte_q <= rf_rdata;
      obf_q      <= 1'b1;
    end else if (host_rd && !host_sel) begin
      obf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= 8'h00;
    else if (host_rd) rdata_q <= host_sel ? status : out_byte_q;
  end

  assign host_rdata = rdata_q;

  ec_port_ibf_timer #(.HOLD(IBF_HOLD)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .set_i     (accept),
    .consume_i (consume),
    .ibf_o     (ibf)
  );

  ec_port_seq #(.AW(AW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .byte_vld    (in_pend_q),
    .byte_i      (in_byte_q),
    .byte_is_cmd (in_cmd_q),
    .consume_o   (consume),
    .reg_rd_en   (rf_rd_en),
    .reg_wr_en   (rf_wr_en),
    .reg_addr    (rf_addr),
    .reg_wdata   (rf_wdata),
    .load_out_o  (load_out)
  );

  ec_port_regfile #(.AW(AW), .DEPTH(REG_DEPTH)) u_regs (
    .clk   (clk),
    .rd_en (rf_rd_en),
    .wr_en (rf_wr_en),
    .addr  (rf_addr),
    .wdata (rf_wdata),
    .rdata (rf_rdata)
  );

  AST_IBF_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ibf && host_wr) |=> ($stable(in_byte_q) && $stable(in_cmd_q))); // R4

  AST_OBF_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (obf_q && host_rd && !host_sel && !load_out) |=> !obf_q); // R5

  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_sel) |=> (host_rdata[7:4] == 4'h0 && host_rdata[2] == 1'b0)); // R2

  AST_SET_WHILE_FREE: assert property (@(posedge clk) disable iff (rst)
    accept |=> (ibf && in_pend_q)); // R3

endmodule

// File: tb/ec_host_port_tb_top.sv
module ec_host_port_tb_top;
  localparam int DEPTH = 16;
  localparam int HOLD  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  ec_host_port #(.REG_DEPTH(DEPTH), .IBF_HOLD(HOLD)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (wr),
    .host_rd    (rd),
    .host_sel   (sel),
    .host_wdata (wdata),
    .host_rdata (rdata)
  );

  task automatic check(input string tag, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic hrd(input logic s, output logic [7:0] v);
    @(negedge clk); rd = 1'b1; sel = s;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic hwr_raw(input logic s, input logic [7:0] b);
    @(negedge clk); wr = 1'b1; sel = s; wdata = b;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_ibf();
    logic [7:0] st;
    for (int i = 0; i < 100; i++) begin
      hrd(1'b1, st);
      if (!st[1]) return;
    end
    check("R3 input-full never cleared", 1, 0);
  endtask

  task automatic hwr(input logic s, input logic [7:0] b);
    wait_ibf();
    hwr_raw(s, b);
  endtask

  task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
    hwr(1'b1, 8'h81); hwr(1'b0, a); hwr(1'b0, d); wait_ibf();
    if (a < DEPTH) model[a] = d;
  endtask

  task automatic ec_read(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] st;
    logic seen;
    hwr(1'b1, 8'h80); hwr(1'b0, a);
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      hrd(1'b1, st);
      if (st[0]) begin seen = 1'b1; break; end
    end
    if (!seen) check("R5 output-full never set", 0, 1);
    hrd(1'b0, v);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] val;
    int n;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    hrd(1'b1, v); check("R1 status after reset", v, 8'h00);
    hrd(1'b0, v); check("R1 data after reset", v, 8'h00);

    // R6 R8 full address sweep: write then read every address
    for (int a = 0; a < 256; a++) ec_write(8'(a), 8'(a * 37 + 11));
    for (int a = 0; a < 256; a++) begin
      ec_read(8'(a), v);
      val = (a < DEPTH) ? 8'(a * 37 + 11) : 8'h00;
      if (a < DEPTH) check("R6 readback", v, val);
      else           check("R8 out-of-range read", v, val);
    end

    // R3 input-full duration, R2 command flag
    wait_ibf();
    @(negedge clk); wr = 1'b1; sel = 1'b1; wdata = 8'h84;
    @(negedge clk); wr = 1'b0; rd = 1'b1; sel = 1'b1;
    @(negedge clk);
    check("R2 cmd flag after command write", int'(rdata[3]), 1);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (!rdata[1]) break;
      n++;
      @(negedge clk);
    end
    rd = 1'b0;
    check("R3 input-full duration", n, HOLD + 1);

    // R5 output-full arrival timing, R2 data flag
    hwr(1'b1, 8'h80); wait_ibf();
    @(negedge clk); wr = 1'b1; sel = 1'b0; wdata = 8'h05;
    @(negedge clk); wr = 1'b0; rd = 1'b1; sel = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); n++;
      if (rdata[0]) break;
    end
    rd = 1'b0;
    check("R5 output-full on third poll", n, 3);
    check("R2 cmd flag clear after data write", int'(rdata[3]), 0);
    hrd(1'b0, v); check("R5 read data", v, model[5]);
    wait_ibf();
    hrd(1'b1, v); check("R5 output-full cleared by data read", int'(v[0]), 0);

    // R4 write while input-full is set is dropped
    hwr(1'b1, 8'h81); hwr_raw(1'b0, 8'h03);
    hwr(1'b0, 8'h06); hwr(1'b0, 8'hAA); wait_ibf(); model[6] = 8'hAA;
    ec_read(8'h06, v); check("R4 sequence intact after busy write", v, 8'hAA);
    ec_read(8'h03, v); check("R4 dropped byte left reg 3", v, model[3]);

    // R7 inert codes inside sequences
    hwr(1'b1, 8'h81); hwr(1'b0, 8'h07); hwr(1'b1, 8'h83);
    hwr(1'b0, 8'h5C); hwr(1'b1, 8'h84); wait_ibf(); model[7] = 8'h5C;
    ec_read(8'h07, v); check("R7 write across inert codes", v, 8'h5C);
    hwr(1'b1, 8'h80); hwr(1'b1, 8'h82); hwr(1'b0, 8'h02);
    for (int i = 0; i < 100; i++) begin hrd(1'b1, v); if (v[0]) break; end
    hrd(1'b0, v); check("R7 read across inert code", v, model[2]);

    // R9 restart by new command
    hwr(1'b1, 8'h81); hwr(1'b0, 8'h08); hwr(1'b1, 8'h80); hwr(1'b0, 8'h09);
    for (int i = 0; i < 100; i++) begin hrd(1'b1, v); if (v[0]) break; end
    hrd(1'b0, v); check("R9 read after aborted write", v, model[9]);
    ec_read(8'h08, v); check("R9 aborted write left reg 8", v, model[8]);

    // R9 unknown code returns to idle
    hwr(1'b1, 8'h81); hwr(1'b0, 8'h0A); hwr(1'b1, 8'h55); hwr(1'b0, 8'h99);
    wait_ibf();
    ec_read(8'h0A, v); check("R9 unknown code aborted write", v, model[10]);

    // R9 stray data byte while idle
    hwr(1'b0, 8'h01); wait_ibf();
    hrd(1'b1, v); check("R9 stray byte leaves status clear", v, 8'h00);
    ec_read(8'h01, v); check("R9 stray byte changed no reg", v, model[1]);

    // R8 out-of-range write dropped, alias location untouched
    ec_write(8'h14, 8'hEE);
    ec_read(8'h04, v); check("R8 alias of dropped write", v, model[4]);
    ec_read(8'h14, v); check("R8 out-of-range still zero", v, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule